// File: doc/BRIEF.md
# Multicycle RISC Datapath

This block is the datapath half of a small 32-bit load/store processor. It executes each instruction over several clock cycles and reuses one ALU and one memory port in every step. The instruction word, the loaded data word, both register operands and the ALU result are held in internal registers between steps. The block decodes no opcodes of its own. An external controller drives every enable and every select line. It reads back the 6-bit opcode field and the ALU zero flag to decide the next step.

The supported set is word load and store, register add, subtract, AND, OR and signed set-on-less-than, branch-if-equal, and an absolute jump within the current 256 MB region. The memory sits outside the block. It returns data combinationally for the address the block presents, and the controller decides when a write takes place, using the block's write-data output.

Top module: `mcd_core`

## Requirements
- R1: With `ir_wr` high, the instruction register loads `mem_rdata` at the clock edge; it holds otherwise. Fetch settings (`pc_wr`=1, `pc_src`=00, `srca_sel`=0, `srcb_sel`=01, `alu_op`=00) advance the PC by 4. `opcode` is bits 31:26 of the instruction register.
- R2: The operand registers A and B load the register-file words addressed by instruction bits 25:21 and 20:16 on every edge. The result register loads the live ALU output on every edge. This lets the decode settings (`srca_sel`=0, `srcb_sel`=11) leave PC + (sign-extended bits 15:0 × 4) in the result register.
- R3: `srca_sel` 0 picks the PC and 1 picks A. `srcb_sel` 00 picks B, 01 the constant 4, 10 the sign-extended bits 15:0, and 11 that value shifted left by 2.
- R4: `alu_op` 00 adds and 01 subtracts. `alu_op` 10 decodes function bits 3:0: 0000 add, 0010 subtract, 0100 AND, 0101 OR, 1010 set-on-less-than.
- R5: The PC is written when `pc_wr` is high, or when `pc_wr_cond` is high and `alu_zero` is high. `pc_src` 00 selects the live ALU output, 01 the result register, and 10 the jump address {PC[31:28], instruction bits 25:0, 00}.
- R6: With `reg_wr` high, the register file writes at the edge. The destination is instruction bits 20:16 when `dst_sel`=0 and bits 15:11 when `dst_sel`=1. The data is the result register when `wb_sel`=0 and the loaded-data register when `wb_sel`=1.
- R7: Register 0 always reads as zero, and a write addressed to it is discarded.
- R8: Set-on-less-than compares as signed and yields 1 or 0. `alu_zero` is high exactly when the ALU output is all zeros.
- R9: `mem_addr` is the PC when `addr_sel`=0 and the result register when `addr_sel`=1. `mem_wdata` is always B.
- R10: Asserting `rst_n` low clears the PC, the instruction, loaded-data, operand and result registers, and the register file, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| pc_wr | input | 1 | Unconditional PC write enable |
| pc_wr_cond | input | 1 | PC write enable qualified by the zero flag |
| addr_sel | input | 1 | Memory address select: 0 PC, 1 result register |
| ir_wr | input | 1 | Instruction register load enable |
| reg_wr | input | 1 | Register file write enable |
| dst_sel | input | 1 | Destination select: 0 bits 20:16, 1 bits 15:11 |
| wb_sel | input | 1 | Write-back select: 0 result register, 1 loaded data |
| srca_sel | input | 1 | ALU input A select |
| srcb_sel | input | 2 | ALU input B select |
| pc_src | input | 2 | Next-PC source select |
| alu_op | input | 2 | ALU operation class |
| mem_rdata | input | 32 | Word read from memory |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data (B) |
| opcode | output | 6 | Instruction bits 31:26 |
| alu_zero | output | 1 | ALU output is zero |

## Verification
Most of the block's state can only be seen through its memory interface. A bad PC shows on `mem_addr` in the next cycle with `addr_sel` low. A bad result register shows there as soon as `addr_sel` goes high. A bad B register shows on `mem_wdata` right after the decode step. A register-file fault stays hidden until a later instruction reads that register, so results are carried forward and stored to memory several instructions after they were written. A wrong taken/not-taken decision shows as a PC error one cycle after the branch step.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_fn_e;

  localparam logic [1:0] SRCB_REG   = 2'b00;
  localparam logic [1:0] SRCB_FOUR  = 2'b01;
  localparam logic [1:0] SRCB_IMM   = 2'b10;
  localparam logic [1:0] SRCB_IMMSH = 2'b11;

  localparam logic [1:0] PCS_ALU  = 2'b00;
  localparam logic [1:0] PCS_HELD = 2'b01;
  localparam logic [1:0] PCS_JUMP = 2'b10;

  localparam logic [1:0] AOP_ADD   = 2'b00;
  localparam logic [1:0] AOP_SUB   = 2'b01;

endpackage

// File: rtl/mcd_regfile.sv
module mcd_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   wa,
  input  logic [XLEN-1:0] wd,
  input  logic [AW-1:0]   ra1,
  input  logic [AW-1:0]   ra2,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2
);

  logic [XLEN-1:0] regs [NREG];
  logic            wr_hit;

  assign wr_hit = we && (wa != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_hit) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

  // R6
  rf_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (regs[$past(wa)] == $past(wd)));

endmodule

// File: rtl/mcd_aluctl.sv
module mcd_aluctl
  import mcd_pkg::*;
(
  input  logic [1:0] alu_op,
  input  logic [5:0] funct,
  output alu_fn_e    fn
);

  always_comb begin
    if (alu_op[1]) begin
      case (funct[3:0])
        4'b0000: fn = ALU_ADD;
        4'b0010: fn = ALU_SUB;
        4'b0100: fn = ALU_AND;
        4'b0101: fn = ALU_OR;
        4'b1010: fn = ALU_SLT;
        default: fn = ALU_ADD;
      endcase
    end else if (alu_op[0]) begin
      fn = ALU_SUB;
    end else begin
      fn = ALU_ADD;
    end
  end

endmodule

// File: rtl/mcd_alu.sv
module mcd_alu
  import mcd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_fn_e         fn,
  output logic [XLEN-1:0] y,
  output logic            zero
);

  logic lt_s;

  assign lt_s = $signed(a) < $signed(b);

  always_comb begin
    case (fn)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, lt_s};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

  always_comb begin
    if (fn == ALU_SUB) begin
      // R8
      sub_zero_eq_chk: assert (zero == (a == b));
    end
  end

endmodule

// File: rtl/mcd_core.sv
module mcd_core
  import mcd_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pc_wr,
  input  logic            pc_wr_cond,
  input  logic            addr_sel,
  input  logic            ir_wr,
  input  logic            reg_wr,
  input  logic            dst_sel,
  input  logic            wb_sel,
  input  logic            srca_sel,
  input  logic [1:0]      srcb_sel,
  input  logic [1:0]      pc_src,
  input  logic [1:0]      alu_op,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic [5:0]      opcode,
  output logic            alu_zero
);

  localparam int AW = $clog2(NREG);
  localparam int IMM_W = 16;
  localparam int JT_W = 26;
  localparam logic [XLEN-1:0] FOUR = XLEN'(4);

  logic [XLEN-1:0] pc_q, pc_d;
  logic [XLEN-1:0] ir_q, ir_d;
  logic [XLEN-1:0] mdr_q, mdr_d;
  logic [XLEN-1:0] a_q, a_d;
  logic [XLEN-1:0] b_q, b_d;
  logic [XLEN-1:0] res_q, res_d;

  logic [XLEN-1:0] rf_rd1, rf_rd2, rf_wd;
  logic [AW-1:0]   rf_wa;
  logic [XLEN-1:0] imm_sx, imm_sh, jmp_tgt;
  logic [XLEN-1:0] op_a, op_b, alu_y;
  logic            pc_en;
  alu_fn_e         fn;

  // instruction fields
  assign opcode  = ir_q[31:26];
  assign imm_sx  = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign imm_sh  = {imm_sx[XLEN-3:0], 2'b00};
  assign jmp_tgt = {pc_q[XLEN-1:XLEN-4], ir_q[JT_W-1:0], 2'b00};

  assign rf_wa = dst_sel ? ir_q[15:11] : ir_q[20:16];
  assign rf_wd = wb_sel ? mdr_q : res_q;

  mcd_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (reg_wr),
    .wa   (rf_wa),
    .wd   (rf_wd),
    .ra1  (ir_q[25:21]),
    .ra2  (ir_q[20:16]),
    .rd1  (rf_rd1),
    .rd2  (rf_rd2)
  );

  // operand selection
  assign op_a = srca_sel ? a_q : pc_q;

  always_comb begin
    case (srcb_sel)
      SRCB_REG:  op_b = b_q;
      SRCB_FOUR: op_b = FOUR;
      SRCB_IMM:  op_b = imm_sx;
      default:   op_b = imm_sh;
    endcase
  end

  mcd_aluctl u_actl (
    .alu_op(alu_op),
    .funct (ir_q[5:0]),
    .fn    (fn)
  );

  mcd_alu #(.XLEN(XLEN)) u_alu (
    .a   (op_a),
    .b   (op_b),
    .fn  (fn),
    .y   (alu_y),
    .zero(alu_zero)
  );

  // memory side
  assign mem_addr  = addr_sel ? res_q : pc_q;
  assign mem_wdata = b_q;

  // next-state logic
  assign pc_en = pc_wr | (pc_wr_cond & alu_zero);

  always_comb begin
    pc_d = pc_q;
    if (pc_en) begin
      case (pc_src)
        PCS_HELD: pc_d = res_q;
        PCS_JUMP: pc_d = jmp_tgt;
        default:  pc_d = alu_y;
      endcase
    end
    ir_d  = ir_wr ? mem_rdata : ir_q;
    mdr_d = mem_rdata;
    a_d   = rf_rd1;
    b_d   = rf_rd2;
    res_d = alu_y;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      mdr_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
    end else begin
      pc_q  <= pc_d;
      ir_q  <= ir_d;
      mdr_q <= mdr_d;
      a_q   <= a_d;
      b_q   <= b_d;
      res_q <= res_d;
    end
  end

  // R5
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pc_wr || (pc_wr_cond && alu_zero)) |=> $stable(pc_q));

  // R1
  ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_wr |=> $stable(ir_q));

  // R1
  fetch_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && pc_src == PCS_ALU && !srca_sel && srcb_sel == SRCB_FOUR && alu_op == AOP_ADD)
      |=> (pc_q == $past(pc_q) + FOUR));

  // R5
  jump_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && pc_src == PCS_JUMP)
      |=> (pc_q[1:0] == 2'b00 && pc_q[XLEN-1:XLEN-4] == $past(pc_q[XLEN-1:XLEN-4])));

endmodule

// File: tb/sim_mcd_core.sv
module sim_mcd_core;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        pc_wr, pc_wr_cond, addr_sel, ir_wr, reg_wr, dst_sel, wb_sel, srca_sel;
  logic [1:0]  srcb_sel, pc_src, alu_op;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic [5:0]  opcode;
  logic        alu_zero;
  logic        mwe;

  logic [31:0] mem [64];
  logic [31:0] rm  [32];
  logic [31:0] pc_m;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  mcd_core u0 (
    .clk(clk), .rst_n(rst_n), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
    .addr_sel(addr_sel), .ir_wr(ir_wr), .reg_wr(reg_wr), .dst_sel(dst_sel),
    .wb_sel(wb_sel), .srca_sel(srca_sel), .srcb_sel(srcb_sel), .pc_src(pc_src),
    .alu_op(alu_op), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .opcode(opcode), .alu_zero(alu_zero)
  );

  assign mem_rdata = mem[mem_addr[7:2]];

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                        input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                        input logic [5:0] funct);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, funct};
  endfunction

  function automatic logic [31:0] model(input logic [5:0] funct, input logic [31:0] a,
                                        input logic [31:0] b);
    case (funct[3:0])
      4'b0010: return a - b;
      4'b0100: return a & b;
      4'b0101: return a | b;
      4'b1010: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return a + b;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    pc_wr = 0; pc_wr_cond = 0; addr_sel = 0; ir_wr = 0; reg_wr = 0;
    dst_sel = 0; wb_sel = 0; srca_sel = 0; srcb_sel = 2'b00; pc_src = 2'b00;
    alu_op = 2'b00; mwe = 0;
  endtask

  task automatic tick();
    logic [5:0]  ca;
    logic [31:0] cd;
    logic        cw;
    #1;
    ca = mem_addr[7:2]; cd = mem_wdata; cw = mwe;
    @(posedge clk);
    if (cw) mem[ca] = cd;
    @(negedge clk);
  endtask

  task automatic fetch_decode(input logic [5:0] op, input logic [15:0] imm, input int rt);
    idle(); ir_wr = 1; pc_wr = 1; srcb_sel = 2'b01;
    tick(); idle();
    pc_m = pc_m + 32'd4;
    #1;
    chk("R1 pc after fetch", mem_addr, pc_m);
    chk("R1 opcode", {26'd0, opcode}, {26'd0, op});
    srcb_sel = 2'b11;
    tick(); idle();
    addr_sel = 1;
    #1;
    chk("R2 decode target", mem_addr, pc_m + {sx(imm)[29:0], 2'b00});
    chk("R2 B holds rt", mem_wdata, rm[rt]);
    addr_sel = 0;
  endtask

  task automatic do_lw(input int rs, input int rt, input logic [15:0] imm);
    logic [31:0] ea;
    fetch_decode(6'd35, imm, rt);
    srca_sel = 1; srcb_sel = 2'b10;
    tick(); idle();
    ea = rm[rs] + sx(imm);
    addr_sel = 1;
    #1 chk("R3 R9 load address", mem_addr, ea);
    tick(); idle();
    wb_sel = 1; reg_wr = 1; dst_sel = 0;
    tick(); idle();
    if (rt != 0) rm[rt] = mem[ea[7:2]];
  endtask

  task automatic do_sw(input int rs, input int rt, input logic [15:0] imm, input string tag);
    logic [31:0] ea;
    fetch_decode(6'd43, imm, rt);
    srca_sel = 1; srcb_sel = 2'b10;
    tick(); idle();
    ea = rm[rs] + sx(imm);
    addr_sel = 1;
    #1 chk("R9 store address", mem_addr, ea);
    mwe = 1;
    tick(); idle();
    chk(tag, mem[ea[7:2]], rm[rt]);
  endtask

  task automatic do_r(input int rs, input int rt, input int rd, input logic [5:0] funct,
                      input string tag);
    logic [31:0] exp;
    fetch_decode(6'd0, {5'(rd), 5'd0, funct}, rt);
    exp = model(funct, rm[rs], rm[rt]);
    srca_sel = 1; srcb_sel = 2'b00; alu_op = 2'b10;
    #1 chk("R8 zero flag", {31'd0, alu_zero}, {31'd0, exp == 32'd0});
    tick(); idle();
    addr_sel = 1;
    #1 chk(tag, mem_addr, exp);
    addr_sel = 0; dst_sel = 1; reg_wr = 1;
    tick(); idle();
    if (rd != 0) rm[rd] = exp;
  endtask

  task automatic do_beq(input int rs, input int rt, input logic [15:0] imm);
    logic [31:0] tgt;
    logic        taken;
    fetch_decode(6'd4, imm, rt);
    tgt = pc_m + {sx(imm)[29:0], 2'b00};
    taken = (rm[rs] == rm[rt]);
    srca_sel = 1; srcb_sel = 2'b00; alu_op = 2'b01; pc_wr_cond = 1; pc_src = 2'b01;
    #1 chk("R8 compare zero", {31'd0, alu_zero}, {31'd0, taken});
    tick(); idle();
    if (taken) pc_m = tgt;
    #1 chk("R5 pc after branch", mem_addr, pc_m);
  endtask

  task automatic do_j(input logic [25:0] t26);
    fetch_decode(6'd2, t26[15:0], int'(t26[20:16]));
    pc_wr = 1; pc_src = 2'b10;
    tick(); idle();
    pc_m = {pc_m[31:28], t26, 2'b00};
    #1 chk("R5 pc after jump", mem_addr, pc_m);
  endtask

  task automatic t_reset();
    rst_n = 0; idle();
    repeat (2) @(negedge clk);
    #1;
    chk("R10 pc cleared", mem_addr, 32'd0);
    chk("R10 B cleared", mem_wdata, 32'd0);
    chk("R10 ir cleared", {26'd0, opcode}, 32'd0);
    addr_sel = 1;
    #1 chk("R10 result cleared", mem_addr, 32'd0);
    addr_sel = 0;
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset_midrun();
    rst_n = 0;
    #1 chk("R10 async pc clear", mem_addr, 32'd0);
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'd0;
    for (int i = 0; i < 32; i++) rm[i] = 32'd0;
    pc_m = 32'd0;
    mem[0]  = enc_i(6'd35, 0, 1, 16'h0040);
    mem[1]  = enc_i(6'd35, 0, 2, 16'h0044);
    mem[2]  = enc_r(1, 2, 3, 6'd32);
    mem[3]  = enc_r(1, 2, 4, 6'd34);
    mem[4]  = enc_r(1, 2, 5, 6'd36);
    mem[5]  = enc_r(1, 2, 6, 6'd37);
    mem[6]  = enc_r(2, 1, 7, 6'd42);
    mem[7]  = enc_r(1, 2, 8, 6'd42);
    mem[8]  = enc_r(1, 1, 0, 6'd32);
    mem[9]  = enc_i(6'd43, 0, 3, 16'h0048);
    mem[10] = enc_i(6'd43, 0, 0, 16'h004C);
    mem[11] = enc_i(6'd4, 1, 1, 16'h0002);
    mem[12] = enc_r(1, 1, 9, 6'd32);
    mem[13] = enc_r(1, 1, 9, 6'd32);
    mem[14] = enc_i(6'd4, 1, 2, 16'h0005);
    mem[15] = {6'd2, 26'h0000020};
    mem[16] = 32'h0000_0007;
    mem[17] = 32'hFFFF_FFFD;
    mem[19] = 32'hDEAD_BEEF;
    mem[32] = enc_i(6'd43, 0, 7, 16'h0050);
    mem[33] = enc_i(6'd35, 3, 9, 16'hFFFC);
    mem[34] = enc_i(6'd43, 0, 9, 16'h0054);

    t_reset();
    do_lw(0, 1, 16'h0040);
    do_lw(0, 2, 16'h0044);
    do_r(1, 2, 3, 6'd32, "R4 add result");
    do_r(1, 2, 4, 6'd34, "R4 sub result");
    do_r(1, 2, 5, 6'd36, "R4 and result");
    do_r(1, 2, 6, 6'd37, "R4 or result");
    do_r(2, 1, 7, 6'd42, "R8 slt signed true");
    do_r(1, 2, 8, 6'd42, "R8 slt signed false");
    do_r(1, 1, 0, 6'd32, "R7 add into r0");
    do_sw(0, 3, 16'h0048, "R6 stored sum from rd");
    do_sw(0, 0, 16'h004C, "R7 r0 reads zero");
    do_beq(1, 1, 16'h0002);
    chk("R5 branch taken pc", pc_m, 32'd56);
    do_beq(1, 2, 16'h0005);
    do_j(26'h0000020);
    chk("R5 jump pc", pc_m, 32'h80);
    do_sw(0, 7, 16'h0050, "R6 slt value stored");
    do_lw(3, 9, 16'hFFFC);
    do_sw(0, 9, 16'h0054, "R3 negative offset load");
    t_reset_midrun();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule